// File: doc/BRIEF.md
# Page Entry Permission Checker and Fault Mapper

This block inspects the eight-bit attribute byte of one leaf or non-leaf page-table entry and decides three things at once: whether the entry points onward to another table level, whether it is malformed, and whether the requested access is allowed. The decision depends on the kind of access, the current privilege and two control bits. One control lets loads see executable-only pages. The other lets supervisor data accesses reach user pages.

It also produces the attribute byte that has to be written back when the accessed or dirty flags must be raised. Separately, it turns a page-walk failure code plus the access kind into an architectural exception number. Every output is combinational. A page walker calls it once per level and once at the leaf, and the exception path is used when the walk gives up.

Top module: `pte_guard`

## Requirements
- R1: `is_pointer` is 1 exactly when attribute bits R (bit 1), W (bit 2) and X (bit 3) are all zero.
- R2: `is_invalid` is 1 when V (bit 0) is zero, or when W (bit 2) is one while R (bit 1) is zero.
- R3: With `priv_lvl`=0 (user), `access_ok` requires U (bit 4)=1. On top of that, fetch (`acc_kind`=0) needs X, load (1) needs R or X-with-`mxr_en`, store (2) needs W, and read-modify-write (3) needs W together with the load condition.
- R4: With `priv_lvl`=1 (supervisor), load, store and read-modify-write need U=0 or `sum_en`=1, plus the same R/W/X condition as R3.
- R5: A supervisor fetch is allowed only when U=0 and X=1. `sum_en` has no effect on it.
- R6: `mxr_en` widens only the read condition, so an X-only page becomes loadable. It never grants fetch or store.
- R7: `upd_needed` is 1 when A (bit 6) is zero, or when the access is store or read-modify-write and D (bit 7) is zero.
- R8: `attr_new` equals `attr_in` with A forced to 1 when an update is needed, and with D also forced to 1 for store and read-modify-write. Without an update it equals `attr_in`.
- R9: `exc_code` is chosen as follows. `fail_code`=0 (memory access error) gives an access fault: 1 for fetch, 5 for load, 7 for store and read-modify-write. Any other code (1 invalid, 2 no permission, 3 misaligned superpage, 4 update disabled) gives a page fault: 12 for fetch, 13 for load, 15 for store and read-modify-write.
- R10: `priv_lvl` of 2 or 3 (machine or reserved) raises `priv_err` and forces `access_ok` to 0. Values 0 and 1 keep `priv_err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| attr_in | input | 8 | Entry attribute byte {D,A,G,U,X,W,R,V} |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 read-modify-write |
| priv_lvl | input | 2 | 0 user, 1 supervisor, 2/3 not checkable |
| mxr_en | input | 1 | Loads may use executable pages |
| sum_en | input | 1 | Supervisor data access to user pages |
| fail_code | input | 3 | Walk failure reason |
| is_pointer | output | 1 | Entry refers to next table level |
| is_invalid | output | 1 | Entry malformed or not valid |
| access_ok | output | 1 | Access permitted |
| priv_err | output | 1 | Privilege outside user/supervisor |
| upd_needed | output | 1 | A/D write-back required |
| attr_new | output | 8 | Attribute byte after A/D update |
| exc_code | output | 5 | Architectural exception number |

## Verification
The embedded assertions assume that every input is a known 0 or 1. Each of them is skipped while any input it reads is unknown, and the bench drives all inputs to defined values before any checking starts. The assertions also treat `access_ok` as meaningful for privileges 0 and 1 only, so the stimulus covers machine and reserved privilege separately and checks only `priv_err` and the forced denial there. The sweep stays inside the defined encodings of `acc_kind` and `fail_code`, and that includes the three unnamed failure codes, which the mapping places among the page faults.

// File: rtl/pte_guard_pkg.sv
package pte_guard_pkg;
  localparam int ATTR_W = 8;
  localparam int ACC_W  = 2;
  localparam int PRV_W  = 2;
  localparam int FAIL_W = 3;
  localparam int EXC_W  = 5;

  localparam int BIT_V = 0;
  localparam int BIT_R = 1;
  localparam int BIT_W = 2;
  localparam int BIT_X = 3;
  localparam int BIT_U = 4;
  localparam int BIT_G = 5;
  localparam int BIT_A = 6;
  localparam int BIT_D = 7;

  typedef enum logic [ACC_W-1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_RMW   = 2'd3
  } acc_e;

  typedef enum logic [PRV_W-1:0] {
    PRV_USER = 2'd0,
    PRV_SUPV = 2'd1,
    PRV_RSVD = 2'd2,
    PRV_MACH = 2'd3
  } prv_e;

  typedef enum logic [FAIL_W-1:0] {
    FL_MEM_ACCESS = 3'd0,
    FL_BAD_ENTRY  = 3'd1,
    FL_NO_PERM    = 3'd2,
    FL_MISALIGN   = 3'd3,
    FL_UPD_OFF    = 3'd4
  } fail_e;

  localparam logic [EXC_W-1:0] EXC_FETCH_ACC  = 5'd1;
  localparam logic [EXC_W-1:0] EXC_LOAD_ACC   = 5'd5;
  localparam logic [EXC_W-1:0] EXC_STORE_ACC  = 5'd7;
  localparam logic [EXC_W-1:0] EXC_FETCH_PAGE = 5'd12;
  localparam logic [EXC_W-1:0] EXC_LOAD_PAGE  = 5'd13;
  localparam logic [EXC_W-1:0] EXC_STORE_PAGE = 5'd15;

  // Load condition, widened by the make-executable-readable control.
  function automatic logic fn_readable(input logic r, input logic x, input logic mxr);
    return r | (x & mxr);
  endfunction

  // R/W/X condition for a given access kind, independent of privilege.
  function automatic logic fn_kind_ok(input acc_e k, input logic r, input logic w,
                                      input logic x, input logic mxr);
    logic rd;
    rd = fn_readable(r, x, mxr);
    unique case (k)
      ACC_FETCH: return x;
      ACC_LOAD:  return rd;
      ACC_STORE: return w;
      default:   return w & rd;
    endcase
  endfunction

  function automatic logic fn_is_write(input acc_e k);
    return (k == ACC_STORE) || (k == ACC_RMW);
  endfunction
endpackage

// File: rtl/pte_shape.sv
module pte_shape (
  input  logic v_bit,
  input  logic r_bit,
  input  logic w_bit,
  input  logic x_bit,
  output logic pointer_o,
  output logic invalid_o
);
  logic leaf_any;
  logic w_without_r;

  always_comb begin
    leaf_any    = r_bit | w_bit | x_bit;
    w_without_r = w_bit & ~r_bit;
    pointer_o   = ~leaf_any;
    invalid_o   = ~v_bit | w_without_r;
  end

  always_comb begin
    if (!$isunknown({v_bit, r_bit, w_bit, x_bit, pointer_o})) begin
      AST_PTR_HAS_NO_RIGHTS: assert (!(pointer_o && (r_bit || w_bit || x_bit))) else $error("pointer with rights"); // R1
      AST_READABLE_NOT_PTR: assert (!(r_bit && pointer_o)) else $error("readable entry flagged pointer"); // R1
    end
    if (!$isunknown({v_bit, r_bit, w_bit, invalid_o})) begin
      AST_NOVALID_IS_BAD: assert (v_bit || invalid_o) else $error("V clear but valid"); // R2
      AST_VR_IS_GOOD: assert (!(v_bit && r_bit && invalid_o)) else $error("V and R set but invalid"); // R2
    end
  end
endmodule

// File: rtl/pte_access_gate.sv
module pte_access_gate
  import pte_guard_pkg::*;
(
  input  acc_e kind,
  input  prv_e prv,
  input  logic u_bit,
  input  logic x_bit,
  input  logic w_bit,
  input  logic r_bit,
  input  logic mxr,
  input  logic sum,
  output logic ok_o,
  output logic bad_prv_o
);
  logic rwx_ok;
  logic user_gate;
  logic supv_data_gate;
  logic supv_exec_gate;

  always_comb begin
    rwx_ok         = fn_kind_ok(kind, r_bit, w_bit, x_bit, mxr);
    user_gate      = u_bit;
    supv_data_gate = ~u_bit | sum;
    supv_exec_gate = ~u_bit;
    bad_prv_o      = 1'b0;
    ok_o           = 1'b0;
    unique case (prv)
      PRV_USER: ok_o = user_gate & rwx_ok;
      PRV_SUPV: ok_o = ((kind == ACC_FETCH) ? supv_exec_gate : supv_data_gate) & rwx_ok;
      default:  bad_prv_o = 1'b1;
    endcase
  end

  always_comb begin
    if (!$isunknown({kind, prv, u_bit, x_bit, w_bit, r_bit, mxr, sum, ok_o, bad_prv_o})) begin
      AST_USER_NEEDS_U: assert (!(ok_o && prv == PRV_USER && !u_bit)) else $error("user access to non-user page"); // R3
      AST_SUPV_DATA_UPAGE: assert (!(ok_o && prv == PRV_SUPV && kind != ACC_FETCH && u_bit && !sum)) else $error("supervisor data on user page"); // R4
      AST_SUPV_EXEC_UPAGE: assert (!(ok_o && prv == PRV_SUPV && kind == ACC_FETCH && u_bit)) else $error("supervisor fetch from user page"); // R5
      AST_FETCH_NEEDS_X: assert (!(ok_o && kind == ACC_FETCH && !x_bit)) else $error("fetch without X"); // R6
      AST_STORE_NEEDS_W: assert (!(ok_o && kind == ACC_STORE && !w_bit)) else $error("store without W"); // R6
      AST_BAD_PRV_DENIED: assert (!(bad_prv_o && ok_o)) else $error("bad privilege allowed"); // R10
    end
  end
endmodule

// File: rtl/pte_ad_writer.sv
module pte_ad_writer
  import pte_guard_pkg::*;
(
  input  logic [ATTR_W-1:0] attr,
  input  acc_e              kind,
  output logic              upd_o,
  output logic [ATTR_W-1:0] attr_o
);
  logic is_wr;
  logic need_a;
  logic need_d;
  logic [ATTR_W-1:0] set_mask;

  always_comb begin
    is_wr    = fn_is_write(kind);
    need_a   = ~attr[BIT_A];
    need_d   = is_wr & ~attr[BIT_D];
    upd_o    = need_a | need_d;
    set_mask = '0;
    if (upd_o) begin
      set_mask[BIT_A] = 1'b1;
      set_mask[BIT_D] = is_wr;
    end
    attr_o = attr | set_mask;
  end

  always_comb begin
    if (!$isunknown({attr, kind, upd_o, attr_o})) begin
      AST_UPD_SETS_A: assert (!upd_o || attr_o[BIT_A]) else $error("update left A clear"); // R8
      AST_LOW_BITS_KEPT: assert (attr_o[BIT_G:0] == attr[BIT_G:0]) else $error("non-A/D bits changed"); // R8
      AST_NO_UPD_SAME: assert (upd_o || attr_o == attr) else $error("byte changed without update"); // R8
      AST_READ_KEEPS_D: assert (fn_is_write(kind) || attr_o[BIT_D] == attr[BIT_D]) else $error("read touched D"); // R8
      AST_CLEAR_A_UPD: assert (attr[BIT_A] || upd_o) else $error("A clear without update"); // R7
    end
  end
endmodule

// File: rtl/walk_fault_mapper.sv
module walk_fault_mapper
  import pte_guard_pkg::*;
(
  input  logic [FAIL_W-1:0] fail,
  input  acc_e              kind,
  output logic [EXC_W-1:0]  exc_o
);
  logic is_mem;

  always_comb begin
    is_mem = (fail == FL_MEM_ACCESS);
    unique case (kind)
      ACC_FETCH: exc_o = is_mem ? EXC_FETCH_ACC : EXC_FETCH_PAGE;
      ACC_LOAD:  exc_o = is_mem ? EXC_LOAD_ACC  : EXC_LOAD_PAGE;
      default:   exc_o = is_mem ? EXC_STORE_ACC : EXC_STORE_PAGE;
    endcase
  end

  always_comb begin
    if (!$isunknown({fail, kind, exc_o})) begin
      AST_EXC_LEGAL: assert (exc_o inside {EXC_FETCH_ACC, EXC_LOAD_ACC, EXC_STORE_ACC,
                                           EXC_FETCH_PAGE, EXC_LOAD_PAGE, EXC_STORE_PAGE}) else $error("illegal exception code"); // R9
      AST_ACCESS_FAULT_LOW: assert ((fail == 3'd0) == (exc_o < 5'd8)) else $error("access/page class mismatch"); // R9
    end
  end
endmodule

// File: rtl/pte_guard.sv
module pte_guard
  import pte_guard_pkg::*;
(
  input  logic [7:0] attr_in,
  input  logic [1:0] acc_kind,
  input  logic [1:0] priv_lvl,
  input  logic       mxr_en,
  input  logic       sum_en,
  input  logic [2:0] fail_code,
  output logic       is_pointer,
  output logic       is_invalid,
  output logic       access_ok,
  output logic       priv_err,
  output logic       upd_needed,
  output logic [7:0] attr_new,
  output logic [4:0] exc_code
);
  acc_e kind;
  prv_e prv;

  assign kind = acc_e'(acc_kind);
  assign prv  = prv_e'(priv_lvl);

  pte_shape u_shape (
    .v_bit     (attr_in[BIT_V]),
    .r_bit     (attr_in[BIT_R]),
    .w_bit     (attr_in[BIT_W]),
    .x_bit     (attr_in[BIT_X]),
    .pointer_o (is_pointer),
    .invalid_o (is_invalid)
  );

  pte_access_gate u_gate (
    .kind      (kind),
    .prv       (prv),
    .u_bit     (attr_in[BIT_U]),
    .x_bit     (attr_in[BIT_X]),
    .w_bit     (attr_in[BIT_W]),
    .r_bit     (attr_in[BIT_R]),
    .mxr       (mxr_en),
    .sum       (sum_en),
    .ok_o      (access_ok),
    .bad_prv_o (priv_err)
  );

  pte_ad_writer u_ad (
    .attr   (attr_in),
    .kind   (kind),
    .upd_o  (upd_needed),
    .attr_o (attr_new)
  );

  walk_fault_mapper u_map (
    .fail  (fail_code),
    .kind  (kind),
    .exc_o (exc_code)
  );

  always_comb begin
    if (!$isunknown({priv_lvl, priv_err})) begin
      AST_PRV_ERR_RANGE: assert (priv_err == priv_lvl[1]) else $error("priv_err for wrong levels"); // R10
    end
  end
endmodule

// File: tb/sim_pte_guard.sv
module sim_pte_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [7:0] attr_in;
  logic [1:0] acc_kind, priv_lvl;
  logic       mxr_en, sum_en;
  logic [2:0] fail_code;
  logic       is_pointer, is_invalid, access_ok, priv_err, upd_needed;
  logic [7:0] attr_new;
  logic [4:0] exc_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  pte_guard u0 (
    .attr_in(attr_in), .acc_kind(acc_kind), .priv_lvl(priv_lvl),
    .mxr_en(mxr_en), .sum_en(sum_en), .fail_code(fail_code),
    .is_pointer(is_pointer), .is_invalid(is_invalid), .access_ok(access_ok),
    .priv_err(priv_err), .upd_needed(upd_needed), .attr_new(attr_new),
    .exc_code(exc_code)
  );

  // {attr, acc, priv, mxr, sum, exp_ok, exp_ptr, exp_inv}
  localparam int NV = 12;
  localparam logic [16:0] VEC [NV] = '{
    {8'h00, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'h01, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {8'h13, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h13, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h13, 2'd1, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {8'h19, 2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h09, 2'd0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h09, 2'd1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h09, 2'd1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},
    {8'h0D, 2'd3, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'h07, 2'd2, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h17, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input bit good, input string tag, input int act, input int exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (attr=%02h acc=%0d prv=%0d mxr=%0b sum=%0b fail=%0d)",
               tag, act, exp, attr_in, acc_kind, priv_lvl, mxr_en, sum_en, fail_code);
    end
  endtask

  // Reference model written from the requirement text.
  function automatic bit ref_ok(input logic [7:0] a, input int k, input int p, input bit m, input bit s);
    bit rd, need;
    rd = a[1] || (a[3] && m);
    case (k)
      0: need = a[3];
      1: need = rd;
      2: need = a[2];
      default: need = a[2] && rd;
    endcase
    if (p == 0) return a[4] && need;
    if (p == 1) begin
      if (k == 0) return !a[4] && a[3];
      return (!a[4] || s) && need;
    end
    return 1'b0;
  endfunction

  function automatic bit ref_upd(input logic [7:0] a, input int k);
    return (a[6] == 1'b0) || (k >= 2 && a[7] == 1'b0);
  endfunction

  function automatic logic [7:0] ref_new(input logic [7:0] a, input int k);
    logic [7:0] n;
    n = a;
    if (ref_upd(a, k)) begin
      n[6] = 1'b1;
      if (k >= 2) n[7] = 1'b1;
    end
    return n;
  endfunction

  function automatic int ref_exc(input int f, input int k);
    int base;
    base = (k == 0) ? 12 : (k == 1) ? 13 : 15;
    return (f == 0) ? base - 11 + ((k == 0) ? 0 : (k == 1) ? 3 : 3) : base;
  endfunction

  task automatic drive(input logic [7:0] a, input int k, input int p, input bit m, input bit s, input int f);
    attr_in = a; acc_kind = k[1:0]; priv_lvl = p[1:0];
    mxr_en = m; sum_en = s; fail_code = f[2:0];
    #2;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    attr_in = '0; acc_kind = '0; priv_lvl = '0; mxr_en = 0; sum_en = 0; fail_code = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state: all-zero inputs
    check(is_pointer == 1'b1, "R1 zero-input pointer", is_pointer, 1);
    check(is_invalid == 1'b1, "R2 zero-input invalid", is_invalid, 1);
    check(access_ok == 1'b0, "R3 zero-input denied", access_ok, 0);
    check(priv_err == 1'b0, "R10 zero-input priv_err", priv_err, 0);
    check(attr_new == 8'h40, "R8 zero-input attr_new", attr_new, 8'h40);
    check(exc_code == 5'd1, "R9 zero-input exc", exc_code, 1);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      drive(v[16:9], int'(v[8:7]), int'(v[6:5]), v[4], v[3], 0);
      check(access_ok == v[2], (v[6:5] == 2'd0) ? "R3 table ok" : "R4 table ok", access_ok, v[2]);
      check(is_pointer == v[1], "R1 table pointer", is_pointer, v[1]);
      check(is_invalid == v[0], "R2 table invalid", is_invalid, v[0]);
      #2;
    end

    // Directed corners: MXR never grants fetch or store (R6)
    drive(8'h19, 0, 0, 1, 0, 0);
    check(access_ok == 1'b1, "R6 user fetch X page", access_ok, 1);
    drive(8'h11, 0, 0, 1, 0, 0);
    check(access_ok == 1'b0, "R6 mxr no fetch grant", access_ok, 0);
    drive(8'h19, 2, 0, 1, 0, 0);
    check(access_ok == 1'b0, "R6 mxr no store grant", access_ok, 0);
    // Supervisor fetch ignores SUM (R5)
    drive(8'h19, 0, 1, 0, 1, 0);
    check(access_ok == 1'b0, "R5 sum ignored on fetch", access_ok, 0);
    // A set D clear on store -> only D rises (R7, R8)
    drive(8'h47, 2, 1, 0, 0, 0);
    check(upd_needed == 1'b1, "R7 store clean page", upd_needed, 1);
    check(attr_new == 8'hC7, "R8 store sets D", attr_new, 8'hC7);
    drive(8'h43, 1, 1, 0, 0, 0);
    check(upd_needed == 1'b0, "R7 load accessed page", upd_needed, 0);
    check(attr_new == 8'h43, "R8 no-update unchanged", attr_new, 8'h43);
    // Machine and reserved privilege (R10)
    for (int p = 2; p < 4; p++) begin
      drive(8'hFF, 1, p, 1, 1, 0);
      check(priv_err == 1'b1, "R10 priv_err high", priv_err, 1);
      check(access_ok == 1'b0, "R10 forced deny", access_ok, 0);
    end

    // Exception mapping sweep (R9)
    for (int f = 0; f < 8; f++)
      for (int k = 0; k < 4; k++) begin
        int e;
        e = ref_exc(f, k);
        drive(8'h00, k, 0, 0, 0, f);
        check(int'(exc_code) == e, "R9 exception map", exc_code, e);
      end

    // Exhaustive permission/shape/update sweep
    for (int a = 0; a < 256; a++)
      for (int k = 0; k < 4; k++)
        for (int p = 0; p < 2; p++)
          for (int m = 0; m < 2; m++)
            for (int s = 0; s < 2; s++) begin
              logic [7:0] av;
              bit eok;
              av = a[7:0];
              eok = ref_ok(av, k, p, m[0], s[0]);
              drive(av, k, p, m[0], s[0], 0);
              check(is_pointer == (av[3:1] == 3'b000), "R1 sweep", is_pointer, av[3:1] == 3'b000);
              check(is_invalid == (!av[0] || (av[2] && !av[1])), "R2 sweep", is_invalid, !av[0] || (av[2] && !av[1]));
              if (p == 0)
                check(access_ok == eok, "R3 sweep", access_ok, eok);
              else if (k == 0)
                check(access_ok == eok, "R5 sweep", access_ok, eok);
              else
                check(access_ok == eok, "R4 sweep", access_ok, eok);
              check(priv_err == 1'b0, "R10 sweep low", priv_err, 0);
              check(upd_needed == ref_upd(av, k), "R7 sweep", upd_needed, ref_upd(av, k));
              check(attr_new == ref_new(av, k), "R8 sweep", attr_new, ref_new(av, k));
            end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule